// File: doc/BRIEF.md
# Core Interrupt Latch, Mask and Pending Controller

This block sits beside a processor core and decides which interrupt the core should take next. Each of its lines has a latch bit that records a request, a mask bit that lets the latched request through, and a pending bit that shows the interrupt is being serviced. Pending bits stay set while an interrupt is nested under another one. Priority is fixed, and a lower line index means a higher priority. A request is offered to the core only if its line beats every line that is already pending.

The core sees a combinational request flag and the index of the chosen line. It answers with an acknowledge strobe, which moves that line from latched to pending. A return-from-interrupt strobe later retires the innermost pending interrupt. Software can clear latch bits by writing ones, and it can write the mask. Two strobes block and unblock all lines at once, and the mask value is kept while the lines are blocked.

Top module: `core_irq_ctrl`

## Requirements
- R1: When `irq_src[i]` is high on a clock edge, `latch_q[i]` is 1 after that edge. The bit stays at 1 until it is cleared under R2 or R4, whatever the mask holds.
- R2: When `ack` is high and `irq_req` is 1, `latch_q[irq_idx]` is cleared on that edge, unless `irq_src` for the same line is also high. When `ack` is high and `irq_req` is 0, the state does not change.
- R3: On the edge of an accepted `ack`, `pend_q[irq_idx]` is set.
- R4: When `clr_we` is high, each latch bit whose `clr_data` bit is 1 is cleared. If the request for the same line is high in the same cycle, the request wins and the bit stays at 1.
- R5: `irq_req` is 1 exactly when some line i has both `latch_q[i]` and `mask_q[i]` set and i is lower than the index of every set `pend_q` bit. `irq_idx` is the lowest such i. Both outputs depend only on the current register state, with no cycle of delay.
- R6: `rti` clears the lowest-index set bit of `pend_q`. It has no effect when `pend_q` is zero. An accepted `ack` in the same cycle still sets its own bit.
- R7: `gdis` while the lines are unblocked saves the mask (or the value written in that cycle) and makes `mask_q` read 0. `gdis` while the lines are already blocked has no effect. A mask write while blocked updates only the saved value.
- R8: `gen` without `gdis`, while the lines are blocked, puts the saved value back into `mask_q`. `gen` while the lines are unblocked has no effect.
- R9: After a synchronous reset, latch, mask and pending are all zero, the lines are unblocked and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_LINES | Request inputs, one per line |
| clr_we | input | 1 | Write strobe for clearing latch bits |
| clr_data | input | NUM_LINES | Write-one-to-clear pattern for the latch |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_LINES | Mask write value |
| gdis | input | 1 | Block all lines, keeping the mask |
| gen | input | 1 | Unblock the lines, restoring the mask |
| ack | input | 1 | Core accepts the offered interrupt |
| rti | input | 1 | Core returns from the innermost interrupt |
| latch_q | output | NUM_LINES | Latch register |
| mask_q | output | NUM_LINES | Mask register as it reads back |
| pend_q | output | NUM_LINES | Read-only pending register |
| irq_req | output | 1 | An interrupt is offered to the core |
| irq_idx | output | IDX_W | Index of the offered line |

## Verification
The assertions check on every cycle the relations that hold from one edge to the next. A raised request is found latched on the next edge. An accepted acknowledge clears the latch bit and sets the pending bit. A return from interrupt drops exactly one pending bit. The offered line always outranks every pending line, and a fresh block leaves the mask at zero. Other behaviours can only be shown by the bench's scenarios: the mask value being restored after a long blocked stretch with writes in it, the request winning against a clear, nesting three levels deep and unwinding in order, and the exact choice of index when many lines compete.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  localparam int DEF_LINES = 16;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         gdis,
  input  logic         gen,
  output logic [N-1:0] mask_q
);
  logic [N-1:0] saved_q;
  logic         blocked_q;
  logic [N-1:0] live_val;
  logic [N-1:0] saved_val;

  assign live_val  = mask_we ? mask_wdata : mask_q;
  assign saved_val = mask_we ? mask_wdata : saved_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      saved_q   <= '0;
      blocked_q <= 1'b0;
    end else if (!blocked_q) begin
      if (gdis) begin
        saved_q   <= live_val;
        mask_q    <= '0;
        blocked_q <= 1'b1;
      end else begin
        mask_q <= live_val;
      end
    end else begin
      saved_q <= saved_val;
      if (gen && !gdis) begin
        mask_q    <= saved_val;
        blocked_q <= 1'b0;
      end
    end
  end

  a_r7_block_zeroes: assert property (@(posedge clk) disable iff (rst)
    (gdis && !blocked_q) |=> (mask_q == '0));
  a_r7_stay_zero: assert property (@(posedge clk) disable iff (rst)
    blocked_q |-> (mask_q == '0));
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] take_idx,
  input  logic         rti,
  output logic [N-1:0] pend_q,
  output logic         pend_any,
  output logic [W-1:0] pend_top
);
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;

  irq_first_set #(.N(N), .W(W)) u_top (
    .vec(pend_q), .any(pend_any), .idx(pend_top)
  );

  generate
    for (genvar g = 0; g < N; g++) begin : g_bits
      assign set_vec[g] = take && (take_idx == W'(g));
      assign clr_vec[g] = rti && pend_any && (pend_top == W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  a_r6_one_retired: assert property (@(posedge clk) disable iff (rst)
    (rti && !take && pend_any) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
  a_r3_pend_set: assert property (@(posedge clk) disable iff (rst)
    take |=> pend_q[$past(take_idx)]);
endmodule

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl
  import core_irq_pkg::*;
#(
  parameter int NUM_LINES = DEF_LINES,
  parameter int IDX_W     = idx_width(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_src,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_data,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic                 gdis,
  input  logic                 gen,
  input  logic                 ack,
  input  logic                 rti,
  output logic [NUM_LINES-1:0] latch_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] pend_q,
  output logic                 irq_req,
  output logic [IDX_W-1:0]     irq_idx
);
  logic                 pend_any;
  logic [IDX_W-1:0]     pend_top;
  logic [NUM_LINES-1:0] eligible;
  logic [NUM_LINES-1:0] ack_clr;
  logic                 take;

  irq_mask_unit #(.N(NUM_LINES)) u_mask (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .gdis(gdis), .gen(gen), .mask_q(mask_q)
  );

  irq_pend_unit #(.N(NUM_LINES), .W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .take(take), .take_idx(irq_idx), .rti(rti),
    .pend_q(pend_q), .pend_any(pend_any), .pend_top(pend_top)
  );

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign eligible[g] = latch_q[g] && mask_q[g] &&
                           (!pend_any || (W_CMP'(g) < W_CMP'(pend_top)));
      assign ack_clr[g]  = take && (irq_idx == IDX_W'(g));
    end
  endgenerate

  localparam int W_CMP = IDX_W + 1;

  irq_first_set #(.N(NUM_LINES), .W(IDX_W)) u_pick (
    .vec(eligible), .any(irq_req), .idx(irq_idx)
  );

  assign take = ack && irq_req;

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= (latch_q & ~ack_clr & ~(clr_we ? clr_data : '0)) | irq_src;
  end

  a_r1_latched: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q & $past(irq_src)) == $past(irq_src)));
  a_r2_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (take && !irq_src[irq_idx]) |=> !latch_q[$past(irq_idx)]);
  a_r5_outranks: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((pend_q & ((NUM_LINES'(1) << irq_idx) | ((NUM_LINES'(1) << irq_idx) - NUM_LINES'(1)))) == '0));
  a_r5_enabled: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (latch_q[irq_idx] && mask_q[irq_idx]));
endmodule

// File: tb/core_irq_ctrl_test.sv
module core_irq_ctrl_test;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 0, rst = 1;
  logic [N-1:0] irq_src = '0, clr_data = '0, mask_wdata = '0;
  logic clr_we = 0, mask_we = 0, gdis = 0, gen = 0, ack = 0, rti = 0;
  logic [N-1:0] latch_q, mask_q, pend_q;
  logic irq_req;
  logic [W-1:0] irq_idx;

  int checks = 0, fails = 0;
  logic [N-1:0] m_latch, m_mask, m_saved, m_pend;
  logic m_blk;
  bit done = 0;

  core_irq_ctrl #(.NUM_LINES(N)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int first_set(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return N;
  endfunction

  function automatic int pick(input logic [N-1:0] l, m, p);
    int lim = first_set(p);
    for (int i = 0; i < N; i++) if (l[i] && m[i] && i < lim) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int p = pick(m_latch, m_mask, m_pend);
    chk("R1/R2/R4 latch", 32'(latch_q), 32'(m_latch));
    chk("R7/R8 mask", 32'(mask_q), 32'(m_mask));
    chk("R3/R6 pend", 32'(pend_q), 32'(m_pend));
    chk("R5 req", 32'(irq_req), 32'(p >= 0));
    if (p >= 0) chk("R5 idx", 32'(irq_idx), 32'(p));
  endtask

  task automatic model_step();
    int p = pick(m_latch, m_mask, m_pend);
    logic [N-1:0] nl = m_latch, np = m_pend, live, sv;
    if (ack && p >= 0) nl[p] = 1'b0;
    if (clr_we) nl = nl & ~clr_data;
    nl = nl | irq_src;
    if (rti && m_pend != 0) np[first_set(m_pend)] = 1'b0;
    if (ack && p >= 0) np[p] = 1'b1;
    live = mask_we ? mask_wdata : m_mask;
    sv = mask_we ? mask_wdata : m_saved;
    if (!m_blk) begin
      if (gdis) begin m_saved = live; m_mask = '0; m_blk = 1; end
      else m_mask = live;
    end else begin
      m_saved = sv;
      if (gen && !gdis) begin m_mask = sv; m_blk = 0; end
    end
    m_latch = nl; m_pend = np;
  endtask

  task automatic cyc(input logic [N-1:0] s, input logic cw, input logic [N-1:0] cd,
                     input logic mw, input logic [N-1:0] md,
                     input logic d, e, a, r);
    irq_src = s; clr_we = cw; clr_data = cd; mask_we = mw; mask_wdata = md;
    gdis = d; gen = e; ack = a; rti = r;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_latch = '0; m_mask = '0; m_saved = '0; m_pend = '0; m_blk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9: reset state
    chk("R9 latch", 32'(latch_q), 0);
    chk("R9 mask", 32'(mask_q), 0);
    chk("R9 pend", 32'(pend_q), 0);
    chk("R9 req", 32'(irq_req), 0);

    // R1: latched while masked
    cyc(16'h0010, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 masked latch", 32'(latch_q[4]), 1);
    chk("R5 no req masked", 32'(irq_req), 0);
    // R2: ack without request ignored
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 ignored ack", 32'(pend_q), 0);
    // R5: enable mask, request appears combinationally
    cyc(16'h0100, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0);
    chk("R5 idx 4", 32'(irq_idx), 4);
    // R2/R3: accept, line 4 pending
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R3 pend 4", 32'(pend_q), 32'h0010);
    chk("R5 8 blocked by 4", 32'(irq_req), 0);
    // nesting: line 1 arrives, taken
    cyc(16'h0002, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R3 nested", 32'(pend_q), 32'h0012);
    // R2: ack with same-line request re-latches
    cyc(16'h0001, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(16'h0001, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 relatch", 32'(latch_q[0]), 1);
    // R4: clear vs request
    cyc(16'h0001, 1, 16'h0101, 0, 0, 0, 0, 0, 0);
    chk("R4 src wins", 32'(latch_q[0]), 1);
    chk("R4 cleared", 32'(latch_q[8]), 0);
    // R6: unwind in order
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6 lowest retired", 32'(pend_q), 32'h0012);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6 empty", 32'(pend_q), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R7/R8: block, write while blocked, restore
    cyc(0, 0, 0, 1, 16'h00F0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 blocked zero", 32'(mask_q), 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 16'h0F0F, 0, 0, 0, 0);
    chk("R7 write hidden", 32'(mask_q), 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 restored", 32'(mask_q), 32'h0F0F);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 noop enable", 32'(mask_q), 32'h0F0F);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] s = N'($urandom) & N'($urandom) & N'($urandom);
      cyc(s, ($urandom % 8) == 0, N'($urandom), ($urandom % 16) == 0, N'($urandom),
          ($urandom % 20) == 0, ($urandom % 12) == 0,
          ($urandom % 3) == 0, ($urandom % 4) == 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule